// File: doc/BRIEF.md
# IO Address Translation Walker

This block turns a device DMA address into a physical memory address by consulting a single-level, linearly indexed translation table that lives in memory. A request carries the DMA address; the control word and the table base are presented alongside it as plain register values. The walker computes where in the table the matching entry sits, fetches that one 64-bit entry through a dedicated memory read port, and returns the physical address together with a page-offset mask, a two-bit permission code and a fault flag.

The span of the table index depends on two control settings: a three-bit table-size code and a window mode that says whether the table is indexed by 8K or by 64K pages of DMA space. Each entry then states on its own whether it maps an 8K or a 64K physical page, so the window mode and the entry page size are independent. With translation switched off, the address is returned unchanged and memory is not touched. A single translation is in flight at a time; the request side, the memory request, the memory response and the result each use a valid/ready style handshake (the memory response is valid-only).

Top module: `iova_xlate_walker`

## Requirements
- R1: With control bit 0 clear, the result is the DMA address zero-extended, offset mask 0x1FFF, permission 3 (read/write), fault 0, and no memory read is issued.
- R2: With control bit 2 clear (8K window) and size code s in control bits 18:16, the entry is read at table base + {dva[22+s:13], 3'b000}, for s = 0 to 7.
- R3: With control bit 2 set (64K window) and size code s from 0 to 5, the entry is read at table base + {dva[25+s:16], 3'b000}.
- R4: In the 64K window, size codes 6 and 7 give a fault with permission 0 and no memory read.
- R5: The memory response carries the byte at the entry address in bits 7:0, the next byte in bits 15:8, and so on; the entry is interpreted big-endian, so that first byte is entry bits 63:56.
- R6: An entry with bit 63 clear yields fault 1, permission 0, physical address 0 and offset mask 0.
- R7: For a valid entry, entry bit 1 set gives permission 3; clear gives permission 1 (read-only). Code 2 never appears.
- R8: A valid entry with bit 61 clear maps an 8K page: physical address = (entry AND 0x1FFFFFFE000) OR dva[12:0], offset mask 0x1FFF.
- R9: A valid entry with bit 61 set maps a 64K page: physical address = (entry AND 0x1FFFFFF8000) OR dva[15:0], offset mask 0xFFFF.
- R10: From request acceptance until the result handshake req_ready is low, and each translation issues at most one memory read.
- R11: Control and base values are taken in the cycle the request is accepted; later changes do not alter that translation.
- R12: After reset req_ready is 1 while mem_req_valid and rsp_valid are 0.
- R13: While a memory request or a result is stalled by its ready signal, it stays asserted with unchanged address and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_dva | input | 32 | DMA address to translate |
| cfg_ctrl | input | 32 | Control: bit 0 enable, bit 2 64K window, bits 18:16 size code |
| cfg_base | input | 41 | Physical byte address of the translation table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 41 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry bytes, lowest address in bits 7:0 |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 41 | Translated physical address |
| rsp_omask | output | 16 | Page-offset mask (0x1FFF or 0xFFFF, 0 on fault) |
| rsp_perm | output | 2 | 0 none, 1 read-only, 3 read/write |
| rsp_fault | output | 1 | Translation failed |

## Verification
The control and base inputs may change in the very cycle the walker's memory response arrives, and in the cycles a result sits stalled, so configuration sampling and entry decoding coincide. The bench provokes this by driving fresh random control and base values immediately after every acceptance, while the memory model answers after a random delay and the result consumer stalls at random. A translation is judged correct only if its entry address, read count and result match the values computed from the configuration present at acceptance, and the result fields stay unchanged through every stall cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int DVA_W     = 32;
    localparam int PA_W      = 41;
    localparam int TTE_W     = 64;
    localparam int BYTE_W    = 8;
    localparam int CTRL_W    = 32;
    localparam int OMASK_W   = 16;

    localparam int EN_BIT    = 0;
    localparam int WIN_BIT   = 2;
    localparam int SZ_LSB    = 16;
    localparam int SZ_W      = 3;

    localparam int TTE_VALID = 63;
    localparam int TTE_BIG   = 61;
    localparam int TTE_WR    = 1;
    localparam int PG8_SH    = 13;
    localparam int PG64_SH   = 16;
    localparam int PHYS64_LO = 15;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd3
    } perm_e;

    typedef struct packed {
        logic            en;
        logic            win64;
        logic [SZ_W-1:0] size;
    } ctrl_t;

    typedef struct packed {
        logic [PA_W-1:0]    paddr;
        logic [OMASK_W-1:0] omask;
        perm_e              perm;
        logic               fault;
    } xres_t;

    function automatic ctrl_t ctrl_fields(input logic [CTRL_W-1:0] c);
        ctrl_t r;
        r.en    = c[EN_BIT];
        r.win64 = c[WIN_BIT];
        r.size  = c[SZ_LSB +: SZ_W];
        return r;
    endfunction

    function automatic xres_t res_fault();
        xres_t r;
        r.paddr = '0;
        r.omask = '0;
        r.perm  = PERM_NONE;
        r.fault = 1'b1;
        return r;
    endfunction

    function automatic xres_t res_bypass(input logic [DVA_W-1:0] a);
        xres_t r;
        r.paddr = PA_W'(a);
        r.omask = OMASK_W'((1 << PG8_SH) - 1);
        r.perm  = PERM_RW;
        r.fault = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/xw_index_calc.sv
module xw_index_calc
    import xw_pkg::*;
#(
    parameter int IDX_MIN_W  = 10,
    parameter int N_SIZES    = 8,
    parameter int MAX64_CODE = 5
) (
    input  ctrl_t            ctrl,
    input  logic [DVA_W-1:0] dva,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  entry_addr,
    output logic             unsupported
);
    localparam int ENT_SH = 3;

    logic [PA_W-1:0] off8_a  [N_SIZES];
    logic [PA_W-1:0] off64_a [N_SIZES];
    logic [PA_W-1:0] off;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int HI8  = PG8_SH + IDX_MIN_W - 1 + s;
        localparam int HI64 = PG64_SH + IDX_MIN_W - 1 + s;
        assign off8_a[s] = PA_W'({dva[HI8:PG8_SH], {ENT_SH{1'b0}}});
        if (s <= MAX64_CODE) begin : g_w64
            assign off64_a[s] = PA_W'({dva[HI64:PG64_SH], {ENT_SH{1'b0}}});
        end else begin : g_none
            assign off64_a[s] = '0;
        end
    end

    always_comb begin
        off         = ctrl.win64 ? off64_a[ctrl.size] : off8_a[ctrl.size];
        unsupported = ctrl.win64 && (int'(ctrl.size) > MAX64_CODE);
        entry_addr  = base + off;
    end

    wire unused_idx = ^{dva[PG8_SH-1:0], dva[DVA_W-1]};

endmodule

// File: rtl/xw_lane_order.sv
module xw_lane_order
    import xw_pkg::*;
(
    input  logic [TTE_W-1:0] raw,
    output logic [TTE_W-1:0] word
);
    localparam int N_LANES = TTE_W / BYTE_W;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        assign word[TTE_W-1-BYTE_W*k -: BYTE_W] = raw[BYTE_W*k +: BYTE_W];
    end

endmodule

// File: rtl/xw_entry_decode.sv
module xw_entry_decode
    import xw_pkg::*;
(
    input  logic [TTE_W-1:0] tte,
    input  logic [DVA_W-1:0] dva,
    output xres_t            res
);
    localparam int PHYS_HI = PA_W - 1;

    logic [PA_W-1:0] base8, base64;

    always_comb begin
        base8  = {tte[PHYS_HI:PG8_SH], {PG8_SH{1'b0}}};
        base64 = {tte[PHYS_HI:PHYS64_LO], {PHYS64_LO{1'b0}}};
        if (!tte[TTE_VALID]) begin
            res = res_fault();
        end else begin
            res.fault = 1'b0;
            res.perm  = tte[TTE_WR] ? PERM_RW : PERM_RO;
            if (tte[TTE_BIG]) begin
                res.paddr = base64 | PA_W'(dva[PG64_SH-1:0]);
                res.omask = OMASK_W'((1 << PG64_SH) - 1);
            end else begin
                res.paddr = base8 | PA_W'(dva[PG8_SH-1:0]);
                res.omask = OMASK_W'((1 << PG8_SH) - 1);
            end
        end
    end

    wire unused_dec = ^{tte[62], tte[60:PA_W], tte[PG8_SH-1:2], tte[0], dva[DVA_W-1:PG64_SH]};

endmodule

// File: rtl/iova_xlate_walker.sv
module iova_xlate_walker
    import xw_pkg::*;
#(
    parameter int IDX_MIN_W  = 10,
    parameter int N_SIZES    = 8,
    parameter int MAX64_CODE = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DVA_W-1:0]   req_dva,
    input  logic [CTRL_W-1:0]  cfg_ctrl,
    input  logic [PA_W-1:0]    cfg_base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [TTE_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [OMASK_W-1:0] rsp_omask,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault
);
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    walk_st_e         st_q;
    logic [DVA_W-1:0] dva_q;
    logic [PA_W-1:0]  eaddr_q;
    xres_t            res_q;

    ctrl_t            ctrl_c;
    logic [PA_W-1:0]  eaddr_c;
    logic             unsup_c;
    logic [TTE_W-1:0] tte_c;
    xres_t            dec_c;

    assign ctrl_c = ctrl_fields(cfg_ctrl);

    xw_index_calc #(
        .IDX_MIN_W (IDX_MIN_W),
        .N_SIZES   (N_SIZES),
        .MAX64_CODE(MAX64_CODE)
    ) u_index (
        .ctrl       (ctrl_c),
        .dva        (req_dva),
        .base       (cfg_base),
        .entry_addr (eaddr_c),
        .unsupported(unsup_c)
    );

    xw_lane_order u_lanes (
        .raw (mem_rsp_data),
        .word(tte_c)
    );

    xw_entry_decode u_decode (
        .tte(tte_c),
        .dva(dva_q),
        .res(dec_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            dva_q   <= '0;
            eaddr_q <= '0;
            res_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        dva_q   <= req_dva;
                        eaddr_q <= eaddr_c;
                        if (!ctrl_c.en) begin
                            res_q <= res_bypass(req_dva);
                            st_q  <= ST_DONE;
                        end else if (unsup_c) begin
                            res_q <= res_fault();
                            st_q  <= ST_DONE;
                        end else begin
                            st_q  <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_q <= dec_c;
                        st_q  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_ISSUE);
    assign mem_req_addr  = eaddr_q;
    assign rsp_valid     = (st_q == ST_DONE);
    assign rsp_paddr     = res_q.paddr;
    assign rsp_omask     = res_q.omask;
    assign rsp_perm      = res_q.perm;
    assign rsp_fault     = res_q.fault;

    wire unused_ctrl = ^{cfg_ctrl[CTRL_W-1:SZ_LSB+SZ_W], cfg_ctrl[SZ_LSB-1:WIN_BIT+1], cfg_ctrl[1]};

endmodule

// File: rtl/xw_walk_checker.sv
module xw_walk_checker
    import xw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [CTRL_W-1:0]  cfg_ctrl,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [PA_W-1:0]    mem_req_addr,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [OMASK_W-1:0] rsp_omask,
    input logic [1:0]         rsp_perm,
    input logic               rsp_fault
);
    logic [1:0]      rd_cnt;
    logic            en_l, win_l;
    logic [SZ_W-1:0] size_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt <= '0;
            en_l   <= 1'b0;
            win_l  <= 1'b0;
            size_l <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt <= '0;
            en_l   <= cfg_ctrl[EN_BIT];
            win_l  <= cfg_ctrl[WIN_BIT];
            size_l <= cfg_ctrl[SZ_LSB +: SZ_W];
        end else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    p_reset_idle_r12: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_req_valid && !rsp_valid));

    p_busy_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    p_one_read_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rd_cnt <= 2'd1));

    p_bypass_noread_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !en_l) |-> (rd_cnt == 2'd0 && rsp_perm == 2'd3 && !rsp_fault));

    p_unsup_fault_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && en_l && win_l && size_l > 3'd5) |-> (rsp_fault && rd_cnt == 2'd0));

    p_fault_noperm_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_perm == 2'd0)));

    p_perm_code_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_perm != 2'd2));

    p_mask_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_omask == 16'h1FFF || rsp_omask == 16'hFFFF));

    p_rsp_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_omask)
                                       && $stable(rsp_perm) && $stable(rsp_fault)));

    p_memreq_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    wire unused_chk = ^{cfg_ctrl[CTRL_W-1:SZ_LSB+SZ_W], cfg_ctrl[SZ_LSB-1:WIN_BIT+1], cfg_ctrl[1]};

endmodule

bind iova_xlate_walker xw_walk_checker u_walk_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .cfg_ctrl     (cfg_ctrl),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_omask    (rsp_omask),
    .rsp_perm     (rsp_perm),
    .rsp_fault    (rsp_fault)
);

// File: tb/sim_iova_xlate_walker.sv
`timescale 1ns/1ps
module sim_iova_xlate_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_dva = '0;
    logic [31:0] cfg_ctrl = '0;
    logic [40:0] cfg_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [40:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [40:0] rsp_paddr;
    logic [15:0] rsp_omask;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    iova_xlate_walker u0 (.*);

    // memory model state
    logic [63:0] mem_word = '0;
    logic [40:0] seen_addr = '0;
    int          n_reads = 0;
    int          mem_wait = 0;

    function automatic logic [63:0] to_lanes(input logic [63:0] w);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[8*k +: 8] = w[56-8*k +: 8];
        return d;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = {$urandom, $urandom};
            if (mem_wait > 0) begin
                mem_wait--;
                if (mem_wait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = to_lanes(mem_word);
                end
            end
            mem_req_ready = ($urandom % 3) != 0;
            if (mem_req_valid && mem_req_ready && mem_wait == 0) begin
                n_reads++;
                seen_addr = mem_req_addr;
                mem_wait  = 1 + ($urandom % 3);
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [40:0] exp_eaddr(input logic [31:0] a, input logic [31:0] c, input logic [40:0] b);
        int unsigned sz = c[18:16];
        logic [63:0] idx;
        logic [63:0] sum;
        if (c[2]) idx = ({32'b0, a} >> 16) & ((64'd1 << (10 + sz)) - 64'd1);
        else      idx = ({32'b0, a} >> 13) & ((64'd1 << (10 + sz)) - 64'd1);
        sum = {23'b0, b} + (idx << 3);
        return sum[40:0];
    endfunction

    task automatic xlate(input logic [31:0] a, input logic [31:0] c, input logic [40:0] b, input logic [63:0] w);
        logic [40:0] e_pa;
        logic [15:0] e_mask;
        logic [1:0]  e_perm;
        logic        e_fault;
        int          e_reads;
        logic [40:0] c_pa;
        logic [15:0] c_mask;
        logic [1:0]  c_perm;
        logic        c_fault;
        bit          busy_ok = 1'b1;
        bit          hold_ok = 1'b1;
        int          guard = 0;
        int          stall;

        // expected values
        e_reads = 1;
        if (!c[0]) begin                           // R1
            e_reads = 0; e_pa = {9'b0, a}; e_mask = 16'h1FFF; e_perm = 2'd3; e_fault = 1'b0;
        end else if (c[2] && c[18:16] > 3'd5) begin // R4
            e_reads = 0; e_pa = '0; e_mask = '0; e_perm = 2'd0; e_fault = 1'b1;
        end else if (!w[63]) begin                  // R6
            e_pa = '0; e_mask = '0; e_perm = 2'd0; e_fault = 1'b1;
        end else begin
            e_perm = w[1] ? 2'd3 : 2'd1;            // R7
            e_fault = 1'b0;
            if (w[61]) begin                        // R9
                e_pa = (w[40:0] & 41'h1FFFFFF8000) | {25'b0, a[15:0]};
                e_mask = 16'hFFFF;
            end else begin                          // R8
                e_pa = (w[40:0] & 41'h1FFFFFFE000) | {28'b0, a[12:0]};
                e_mask = 16'h1FFF;
            end
        end

        mem_word = w;
        n_reads  = 0;
        seen_addr = '1;
        @(negedge clk);
        req_dva = a; cfg_ctrl = c; cfg_base = b; req_valid = 1'b1;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        // R11: configuration changes after acceptance must not matter
        cfg_ctrl = $urandom;
        cfg_base = {$urandom, $urandom};
        while (!rsp_valid && guard < 1000) begin
            if (req_ready) busy_ok = 1'b0;
            cfg_ctrl = $urandom;
            @(negedge clk); guard++;
        end
        c_pa = rsp_paddr; c_mask = rsp_omask; c_perm = rsp_perm; c_fault = rsp_fault;
        stall = $urandom % 3;
        for (int i = 0; i < stall; i++) begin
            rsp_ready = 1'b0;
            cfg_base = {$urandom, $urandom};
            @(negedge clk);
            if (!rsp_valid || rsp_paddr != c_pa || rsp_omask != c_mask ||
                rsp_perm != c_perm || rsp_fault != c_fault || req_ready) hold_ok = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        chk(guard < 1000, "R10 handshake completes", 64'(guard), 64'd0);
        chk(c_pa == e_pa, "R8/R9/R5 physical address", 64'(c_pa), 64'(e_pa));
        chk(c_mask == e_mask, "R8/R9 offset mask", 64'(c_mask), 64'(e_mask));
        chk(c_perm == e_perm && c_fault == e_fault, "R6/R7 permission and fault",
            {62'(c_fault), c_perm}, {62'(e_fault), e_perm});
        chk(n_reads == e_reads, "R10 memory read count (R1 R4 when zero)", 64'(n_reads), 64'(e_reads));
        if (e_reads == 1)
            chk(seen_addr == exp_eaddr(a, c, b), c[2] ? "R3 entry address" : "R2 entry address",
                64'(seen_addr), 64'(exp_eaddr(a, c, b)));
        chk(busy_ok, "R10 req_ready low while busy", 64'(busy_ok), 64'd1);
        chk(hold_ok, "R13 result held during stall", 64'(hold_ok), 64'd1);
    endtask

    localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] BG = 64'h2000_0000_0000_0000;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired (R10) actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(req_ready && !mem_req_valid && !rsp_valid, "R12 reset outputs",
            {61'b0, req_ready, mem_req_valid, rsp_valid}, 64'h4);

        // R1 bypass
        xlate(32'hDEAD_BEEF, 32'h0007_0004, 41'h123_4567_8000, V | 64'h2);
        // R2 8K window, sizes 0 and 7, R7 read-only and R8 8K page
        xlate(32'hFFFF_FFFF, 32'h0000_0001, 41'h100_0000_0000, V | 64'h0000_0123_4567_A001);
        xlate(32'hFFFF_FFFF, 32'h0007_0001, 41'h000_0000_1000, V | 64'h2);
        // R3 64K window size 5, R9 64K page with bit 15 overlap, R5 lane order
        xlate(32'h7FFF_8ABC, 32'h0005_0005, 41'h0AB_CDEF_0000, V | BG | 64'h0000_01AB_CDEF_8002);
        xlate(32'h1234_5678, 32'h0000_0005, 41'h1FF_FFFF_FFF8, V | BG | 64'h0000_0000_0001_0000);
        // R4 unsupported 64K codes
        xlate(32'h0001_0000, 32'h0006_0005, 41'h0, V | 64'h2);
        xlate(32'h0001_0000, 32'h0007_0005, 41'h0, V | 64'h2);
        // R6 invalid entry
        xlate(32'h0000_2000, 32'h0003_0001, 41'h40_0000, BG | 64'h0000_01FF_FFFF_E002);
        // R5 distinct byte pattern
        xlate(32'h0000_0ABC, 32'h0000_0001, 41'h0, 64'h8102_0304_0506_0702);

        // constrained random mix
        for (int n = 0; n < 150; n++) begin
            logic [31:0] c;
            logic [63:0] w;
            c = $urandom;
            c[0] = ($urandom % 8) != 0;
            w = {$urandom, $urandom};
            w[63] = ($urandom % 6) != 0;
            xlate($urandom, c, {$urandom, $urandom}, w);
        end
        finish_run();
    end

endmodule